// File: doc/BRIEF.md
# Pulse Interval Averaging Meter

This block times a digital pulse train against a slow free-running tick and reports a smoothed interval. The raw pulse input passes through a two-stage synchronizer and an edge detector. A timer then counts ticks between a starting rising edge and a closing edge. A mode pin selects the closing edge: the falling edge gives the high time, and the next rising edge gives the period. In period mode that same rising edge also opens the next interval.

Each finished interval goes into an eight-slot circular store. A running sum is kept by adding the new sample and removing the sample it replaces. The average is the sum shifted right by three. A valid flag tells the consumer when eight samples have accumulated. If the line goes quiet, the timer does not wrap. It publishes the largest count it can hold, which stands for "no pulses" (zero rate).

By default one tick is 20000 clocks, which is 100 us at 200 MHz. The counter width sets the longest interval that can be told apart from silence.

Top module: `pulse_avg_meter`

## Requirements
- R1: While reset is low, and on the first edge after it, `interval_o` and `average_o` are 0 and `valid_o` is 0, whatever was stored before.
- R2: With `mode_sel` = 0, a sample equals the number of ticks from a rising edge to the next falling edge of `pulse_in`. One tick is TICK_DIV clocks, so with TICK_DIV = 1 the sample is the high time in clocks.
- R3: With `mode_sel` = 1, a sample equals the ticks between two successive rising edges, and falling edges have no effect. The first rising edge after reset, or after a saturation, only starts timing and publishes nothing.
- R4: Outputs change only when a sample is published. A published sample appears on `interval_o`, together with the updated average, after the third rising clock edge that follows the input transition closing the interval.
- R5: `average_o` is the floor of the sum of the eight most recent samples divided by eight. Slots not yet written since reset count as zero.
- R6: `valid_o` is low until eight samples have been published since reset. It rises with the eighth sample and then stays high.
- R7: If timing runs for MAX+1 ticks without a closing edge, where MAX = 2^CNT_W − 1, the value MAX is published once and timing stops until the next rising edge. A closing edge that arrives while timing is stopped publishes nothing.
- R8: When a closing edge falls on the same tick at which saturation would occur, exactly one sample of value MAX is published. In period mode that edge still opens the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse line being measured |
| mode_sel | input | 1 | 0 = high-time measurement, 1 = period measurement |
| interval_o | output | CNT_W | Most recently published interval in ticks |
| average_o | output | CNT_W | Mean of the last eight published intervals |
| valid_o | output | 1 | High once eight intervals have been published |

## Verification
Two functions can fall in the same cycle:
- a period-mode rising edge, which closes one interval and opens the next;
- the saturation tick, which would close the interval on its own.

The bench provokes the collision by running TICK_DIV = 1 with a 6-bit counter and a pulse period of exactly 64 clocks. Every closing edge then lands on the tick at which the counter would saturate. The collision is judged correct if each period yields a single sample of 63, no interval is lost, and `valid_o` rises on precisely the eighth such sample. A longer period that follows must instead produce one saturation sample and an arming-only edge.

// File: rtl/pam_pkg.sv
package pam_pkg;

    typedef enum logic {
        MEAS_HIGH   = 1'b0,
        MEAS_PERIOD = 1'b1
    } meas_mode_e;

endpackage

// File: rtl/pam_tick_gen.sv
module pam_tick_gen #(
    parameter int DIV = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.pre == LAST);
        if (tick_o) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pam_edge_sync.sv
module pam_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        synced;

    assign synced = st_q.sh[STAGES-1];

    always_comb begin
        st_d       = st_q;
        st_d.sh[0] = sig_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
        st_d.prev = synced;
        rise_o    = synced & ~st_q.prev;
        fall_o    = ~synced & st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pam_interval_timer.sv
module pam_interval_timer
    import pam_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  meas_mode_e       mode_i,
    output logic             push_o,
    output logic [CNT_W-1:0] sample_o,
    output logic             sat_o,
    output logic             armed_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic             close_evt;
    logic [CNT_W-1:0] cnt_inc;

    assign armed_o = st_q.armed;

    always_comb begin
        st_d    = st_q;
        cnt_inc = (st_q.cnt == CMAX) ? CMAX : st_q.cnt + 1'b1;

        // closing edge depends on the measurement kind
        if (mode_i == MEAS_PERIOD) begin
            close_evt = st_q.armed & rise_i;
        end else begin
            close_evt = st_q.armed & fall_i;
        end

        // saturation only when no closing edge shares the tick
        sat_o  = st_q.armed & tick_i & (st_q.cnt == CMAX) & ~close_evt;
        push_o = close_evt | sat_o;

        if (close_evt) begin
            sample_o = tick_i ? cnt_inc : st_q.cnt;
        end else begin
            sample_o = CMAX;
        end

        if (rise_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (close_evt || sat_o) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (st_q.armed && tick_i) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pam_avg_ring.sv
module pam_avg_ring #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] last_o,
    output logic [W-1:0] avg_o,
    output logic         full_o
);
    localparam int AW     = $clog2(DEPTH);
    localparam int SUM_W  = W + AW;
    localparam int FILL_W = AW + 1;
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [SUM_W-1:0]        sum;
        logic [FILL_W-1:0]       fill;
        logic [W-1:0]            last;
    } ring_state_t;

    ring_state_t st_d, st_q;
    logic [W-1:0] oldest;

    assign last_o = st_q.last;
    assign avg_o  = st_q.sum[SUM_W-1:AW];
    assign full_o = (st_q.fill == FULL_CNT);

    always_comb begin
        st_d   = st_q;
        oldest = st_q.mem[st_q.wptr];
        if (push_i) begin
            st_d.mem[st_q.wptr] = sample_i;
            st_d.sum  = st_q.sum + SUM_W'(sample_i) - SUM_W'(oldest);
            st_d.wptr = st_q.wptr + 1'b1;
            st_d.last = sample_i;
            if (st_q.fill != FULL_CNT) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pulse_avg_meter.sv
module pulse_avg_meter
    import pam_pkg::*;
#(
    parameter int TICK_DIV    = 20000,
    parameter int CNT_W       = 16,
    parameter int AVG_DEPTH   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             mode_sel,
    output logic [CNT_W-1:0] interval_o,
    output logic [CNT_W-1:0] average_o,
    output logic             valid_o
);
    logic             tick;
    logic             edge_rise;
    logic             edge_fall;
    logic             smp_push;
    logic             smp_sat;
    logic             tmr_armed;
    logic [CNT_W-1:0] smp_val;
    meas_mode_e       mode;

    assign mode = meas_mode_e'(mode_sel);

    pam_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    pam_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (pulse_in),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    pam_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .rise_i   (edge_rise),
        .fall_i   (edge_fall),
        .mode_i   (mode),
        .push_o   (smp_push),
        .sample_o (smp_val),
        .sat_o    (smp_sat),
        .armed_o  (tmr_armed)
    );

    pam_avg_ring #(.W(CNT_W), .DEPTH(AVG_DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (smp_push),
        .sample_i (smp_val),
        .last_o   (interval_o),
        .avg_o    (average_o),
        .full_o   (valid_o)
    );
endmodule

// File: rtl/pam_checker.sv
module pam_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         push_i,
    input logic         sat_i,
    input logic         armed_i,
    input logic [W-1:0] interval_i,
    input logic [W-1:0] average_i,
    input logic         valid_i
);
    localparam logic [W-1:0] CMAX = '1;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (interval_i == '0 && average_i == '0 && !valid_i))
        else $error("reset did not clear outputs");

    p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !push_i |=> ($stable(interval_i) && $stable(average_i)))
        else $error("outputs moved without a sample");

    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_i)
        else $error("valid dropped");

    p_sat_only_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_i |-> armed_i)
        else $error("saturation while idle");

    p_sat_publish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_i |=> (interval_i == CMAX && !armed_i))
        else $error("saturation did not publish max and stop");
endmodule

bind pulse_avg_meter pam_checker #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (smp_push),
    .sat_i      (smp_sat),
    .armed_i    (tmr_armed),
    .interval_i (interval_o),
    .average_i  (average_o),
    .valid_i    (valid_o)
);

// File: tb/pulse_avg_meter_test.sv
module pulse_avg_meter_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W    = 6;
    localparam int MAXV = 63;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pulse_in = 1'b0;
    logic         mode_sel = 1'b0;
    logic [W-1:0] interval_o;
    logic [W-1:0] average_o;
    logic         valid_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    int ring [8];
    int nfill = 0;
    int widx = 0;
    int exp_last = 0;

    pulse_avg_meter #(.TICK_DIV(1), .CNT_W(W), .AVG_DEPTH(8), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_in   (pulse_in),
        .mode_sel   (mode_sel),
        .interval_o (interval_o),
        .average_o  (average_o),
        .valid_o    (valid_o)
    );

    always #2.5 clk = ~clk;

    task automatic model_clear();
        for (int i = 0; i < 8; i++) ring[i] = 0;
        nfill = 0;
        widx = 0;
        exp_last = 0;
    endtask

    task automatic model_push(input int v);
        ring[widx] = v;
        widx = (widx + 1) % 8;
        if (nfill < 8) nfill++;
        exp_last = v;
    endtask

    task automatic chk(input string rq);
        int s = 0;
        int ea;
        bit ev;
        for (int i = 0; i < 8; i++) s += ring[i];
        ea = s / 8;
        ev = (nfill >= 8);
        checks++;
        if (int'(interval_o) !== exp_last || int'(average_o) !== ea || valid_o !== ev) begin
            bad++;
            $display("FAIL %s: interval=%0d avg=%0d valid=%0b expected interval=%0d avg=%0d valid=%0b",
                     rq, interval_o, average_o, valid_o, exp_last, ea, ev);
        end
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n = 1'b0;
        pulse_in = 1'b0;
        mode_sel = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int h, input int l);
        pulse_in = 1'b1;
        repeat (h) @(negedge clk);
        pulse_in = 1'b0;
        repeat (l) @(negedge clk);
    endtask

    // R1: outputs zero straight after reset
    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1 reset state");
    endtask

    // R2, R4, R5, R6: high-time samples, running average, valid after eight
    task automatic t_high_time();
        int hs [10];
        hs = '{5, 7, 9, 4, 12, 6, 10, 8, 11, 3};
        do_reset(1'b0);
        foreach (hs[k]) begin
            pulse(hs[k], 6);
            model_push(hs[k]);
            chk(k < 7 ? "R2 R5 high time, valid low" : "R6 R5 high time, window full");
        end
        // R1: reset clears a filled window
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        model_clear();
        chk("R1 reset clears stored samples");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R3: rising-to-rising period, first edge only arms, falls ignored
    task automatic t_period();
        int ls [10];
        ls = '{5, 9, 4, 13, 7, 6, 10, 8, 12, 5};
        do_reset(1'b1);
        foreach (ls[k]) begin
            pulse(3, ls[k]);
            if (k > 0) model_push(3 + ls[k-1]);
            chk(k == 0 ? "R3 first rise only arms" : "R3 R4 period sample");
        end
    endtask

    // R7: a too-long high time publishes MAX once, late fall ignored
    task automatic t_sat_high();
        do_reset(1'b0);
        pulse_in = 1'b1;
        repeat (MAXV + 5) @(negedge clk);
        model_push(MAXV);
        chk("R7 saturation publishes max");
        repeat (15) @(negedge clk);
        pulse_in = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 fall after saturation ignored");
        pulse(5, 6);
        model_push(5);
        chk("R7 timing resumes on next rise");
    endtask

    // R8: closing edge on the saturating tick, then a true silence
    task automatic t_coincide();
        do_reset(1'b1);
        for (int k = 0; k < 10; k++) begin
            pulse(3, MAXV - 2);
            if (k > 0) model_push(MAXV);
            chk("R8 R6 edge on saturation tick");
        end
        pulse(3, MAXV + 2);
        model_push(MAXV);
        model_push(MAXV);
        chk("R7 R8 long period saturates once");
        pulse(3, 7);
        chk("R7 rise after saturation only arms");
        pulse(3, 7);
        model_push(10);
        chk("R3 period after re-arm");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_high_time();
        t_period();
        t_sat_high();
        t_coincide();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule